// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from a cold start to the point where normal traffic may begin. It watches a power-good input. Once that input is high, it raises the clock enable and holds the bus at NOP for the long stabilisation window. It then issues a fixed, ordered chain of commands. Between commands it inserts NOP cycles so that each precharge, mode-load and refresh spacing is met, counted in clock cycles that are derived from the clock period parameter. When the chain is complete and the DLL has had its lock time, it raises a done flag and leaves the bus at NOP for the memory controller to take over.

The command order is: precharge-all, then extended mode register 2, then register 3, then the extended mode register with the DLL enabled, then the base mode register with DLL reset, then a second precharge-all, then a configurable number of refreshes, then the base mode register again without DLL reset, then the extended mode register with the output-driver calibration field at default, and last with that field at exit. The mode-register contents come from four configuration inputs. The sequencer forces only the bits that the sequence itself defines.

States: `S_IDLE`, `S_PWRUP`, `S_PREA1`, `S_EMR2`, `S_EMR3`, `S_EMR_DLL`, `S_MR_DLLRST`, `S_PREA2`, `S_REFRESH`, `S_MR_RUN`, `S_EMR_OCD`, `S_EMR_EXIT`, `S_HOLD`, `S_DONE`. Transitions:
- Leaving `S_IDLE`: power-good is seen high.
- Leaving `S_PWRUP`: the power-up wait has expired.
- Leaving each command state: the spacing timer is zero, the command is issued, and the state moves to the next one in the order above.
- `S_REFRESH`: stays in place until the last refresh has been issued.
- Leaving `S_HOLD`: the final mode-load spacing has elapsed and the DLL wait has expired.
- `S_DONE`: stays in place.
- Any state goes back to `S_IDLE` when power-good is seen low.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and from the cycle after power-good is sampled low, the block drives `cke`=0, `init_done`=0, `ba`=0 and `addr`=0, with the NOP command. The command is {cs_n,ras_n,cas_n,we_n}, and NOP is 0111.
- R2: `cke` rises in the first cycle after power-good is sampled high and stays high while power-good stays high. Only NOPs are driven until the first precharge-all, which comes PWR_CYC+PRE_CYC cycles after `cke` rises. PWR_CYC is ceil(200 µs / period) and PRE_CYC is ceil(400 ns / period).
- R3: Precharge-all is command 0010 with `addr`[10]=1, all other address bits 0 and `ba`=0. The second precharge-all comes tMRD cycles after the DLL-reset load.
- R4: Mode load is command 0000. The load to `ba`=2 with `addr`=`emr2_cfg` comes tRP cycles after the first precharge. The load to `ba`=3 with `addr`=`emr3_cfg` comes tMRD cycles after that.
- R5: tMRD cycles after the `ba`=3 load, a load to `ba`=1 carries `emr_cfg` with bit 0 (DLL enable, active low) and bits 9:7 cleared.
- R6: tMRD cycles later, a load to `ba`=0 carries `mr_cfg` with bit 8 (DLL reset) set.
- R7: REF_COUNT refreshes (command 0001, `addr`=0, `ba`=0) follow. The first comes tRP cycles after the second precharge, and each later one comes tRFC cycles after the previous one.
- R8: tRFC cycles after the last refresh, a load to `ba`=0 carries `mr_cfg` with bit 8 cleared.
- R9: Two loads to `ba`=1 follow, each tMRD cycles after the one before. The first carries `emr_cfg` with bits 9:7 = 111 and the second carries it with bits 9:7 = 000. In both, bit 0 is cleared and every other bit keeps its configured value.
- R10: `init_done` first rises one cycle after the later of two points: tMRD cycles after the last load, and DLL_LOCK cycles after the DLL-reset load. It stays high while power-good stays high, and the bus stays at NOP while it is high.
- R11: `odt` is 0 at all times.
- R12: When power-good falls mid-sequence and later rises again, the sequence restarts from the full power-up wait with the current configuration.
- R13: In every cycle without a scheduled command, the bus carries NOP with `ba`=0 and `addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supplies and clock are stable |
| mr_cfg | input | ROW_W | Base mode register contents |
| emr_cfg | input | ROW_W | Extended mode register contents |
| emr2_cfg | input | ROW_W | Extended mode register 2 contents |
| emr3_cfg | input | ROW_W | Extended mode register 3 contents |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
Every output comes from registered state through combinational decode. A command therefore shows on the pins in the same cycle that the state machine sees its spacing timer at zero. `cke` follows a power-good change one cycle later. `init_done` rises one cycle after both of its waits are satisfied. The bench model works out the absolute cycle of each command from the moment `cke` rises, using only the spacings in the requirements. It steps its cycle count at each rising edge and compares every pin at the following falling edge, so each expected value is sampled in the exact cycle it is due and never at an edge. A mid-sequence power-good drop and a second configuration check the restart and the forced bits.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWRUP,
        S_PREA1,
        S_EMR2,
        S_EMR3,
        S_EMR_DLL,
        S_MR_DLLRST,
        S_PREA2,
        S_REFRESH,
        S_MR_RUN,
        S_EMR_OCD,
        S_EMR_EXIT,
        S_HOLD,
        S_DONE
    } state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LMR = 4'b0000;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
        int c;
        c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Down-counter used for every spacing in the sequence.
module ddr2_init_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2_init_dll_wait.sv
// Counts cycles since the DLL-reset load and flags when the lock time is over.
module ddr2_init_dll_wait #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] LOCK_V = CW'(LOCK_CYC);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start) begin
            cnt   <= CW'(1);
            armed <= 1'b1;
        end else if (armed && cnt < LOCK_V) begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign expired = armed && (cnt >= LOCK_V);
endmodule

// File: rtl/ddr2_init_cmd_enc.sv
// Maps the current step to pin values; NOP unless the step fires.
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2
) (
    input  state_e            step,
    input  logic              fire,
    input  logic [ROW_W-1:0]  mr_cfg,
    input  logic [ROW_W-1:0]  emr_cfg,
    input  logic [ROW_W-1:0]  emr2_cfg,
    input  logic [ROW_W-1:0]  emr3_cfg,
    output logic [3:0]        cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr
);
    function automatic logic [ROW_W-1:0] emr_word(input logic [ROW_W-1:0] cfg,
                                                  input logic [2:0] ocd);
        logic [ROW_W-1:0] w;
        w      = cfg;
        w[0]   = 1'b0;
        w[9:7] = ocd;
        return w;
    endfunction

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (fire) begin
            unique case (step)
                S_PREA1, S_PREA2: begin
                    cmd      = CMD_PRE;
                    addr[10] = 1'b1;
                end
                S_EMR2: begin
                    cmd  = CMD_LMR;
                    ba   = BANK_W'(2);
                    addr = emr2_cfg;
                end
                S_EMR3: begin
                    cmd  = CMD_LMR;
                    ba   = BANK_W'(3);
                    addr = emr3_cfg;
                end
                S_EMR_DLL, S_EMR_EXIT: begin
                    cmd  = CMD_LMR;
                    ba   = BANK_W'(1);
                    addr = emr_word(emr_cfg, 3'b000);
                end
                S_EMR_OCD: begin
                    cmd  = CMD_LMR;
                    ba   = BANK_W'(1);
                    addr = emr_word(emr_cfg, 3'b111);
                end
                S_MR_DLLRST: begin
                    cmd     = CMD_LMR;
                    addr    = mr_cfg;
                    addr[8] = 1'b1;
                end
                S_MR_RUN: begin
                    cmd     = CMD_LMR;
                    addr    = mr_cfg;
                    addr[8] = 1'b0;
                end
                S_REFRESH: cmd = CMD_REF;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_PS      = 10000,
    parameter int T_PWR_NS    = 200000,
    parameter int T_PRE_NS    = 400,
    parameter int T_RP_NS     = 15,
    parameter int T_RFC_NS    = 128,
    parameter int T_MRD_CK    = 2,
    parameter int REF_COUNT   = 2,
    parameter int DLL_LOCK_CK = 200,
    parameter int ROW_W       = 14,   // at least 11: bits 10, 9:7, 8, 0 are used
    parameter int BANK_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic [ROW_W-1:0]  mr_cfg,
    input  logic [ROW_W-1:0]  emr_cfg,
    input  logic [ROW_W-1:0]  emr2_cfg,
    input  logic [ROW_W-1:0]  emr3_cfg,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);
    localparam int PWR_CYC = ns_to_cyc(T_PWR_NS, CLK_PS);
    localparam int PRE_CYC = ns_to_cyc(T_PRE_NS, CLK_PS);
    localparam int RP_CYC  = ns_to_cyc(T_RP_NS, CLK_PS);
    localparam int RFC_CYC = ns_to_cyc(T_RFC_NS, CLK_PS);
    localparam int MRD_CYC = (T_MRD_CK < 1) ? 1 : T_MRD_CK;
    localparam int PWR_TOT = PWR_CYC + PRE_CYC;
    localparam int TW      = $clog2(PWR_TOT + 1);
    localparam int RCW     = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;

    localparam logic [TW-1:0]  LD_PWR = TW'(PWR_TOT - 1);
    localparam logic [TW-1:0]  LD_RP  = TW'(RP_CYC - 1);
    localparam logic [TW-1:0]  LD_RFC = TW'(RFC_CYC - 1);
    localparam logic [TW-1:0]  LD_MRD = TW'(MRD_CYC - 1);
    localparam logic [RCW-1:0] REF_LAST = RCW'(REF_COUNT - 1);

    state_e         st, st_n;
    logic           t_load, t_zero;
    logic [TW-1:0]  t_val;
    logic [RCW-1:0] ref_cnt;
    logic           ref_inc;
    logic           fire;
    logic           dll_start, dll_expired;
    logic [3:0]     cmd;

    // State register and refresh counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ref_cnt <= '0;
        end else begin
            st <= st_n;
            if (st != S_REFRESH)
                ref_cnt <= '0;
            else if (ref_inc)
                ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // Next state and timer loads
    always_comb begin
        st_n    = st;
        t_load  = 1'b0;
        t_val   = '0;
        ref_inc = 1'b0;
        if (!pwr_good) begin
            st_n = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE: begin
                    st_n   = S_PWRUP;
                    t_load = 1'b1;
                    t_val  = LD_PWR;
                end
                S_PWRUP:     if (t_zero) st_n = S_PREA1;
                S_PREA1:     if (t_zero) begin st_n = S_EMR2;      t_load = 1'b1; t_val = LD_RP;  end
                S_EMR2:      if (t_zero) begin st_n = S_EMR3;      t_load = 1'b1; t_val = LD_MRD; end
                S_EMR3:      if (t_zero) begin st_n = S_EMR_DLL;   t_load = 1'b1; t_val = LD_MRD; end
                S_EMR_DLL:   if (t_zero) begin st_n = S_MR_DLLRST; t_load = 1'b1; t_val = LD_MRD; end
                S_MR_DLLRST: if (t_zero) begin st_n = S_PREA2;     t_load = 1'b1; t_val = LD_MRD; end
                S_PREA2:     if (t_zero) begin st_n = S_REFRESH;   t_load = 1'b1; t_val = LD_RP;  end
                S_REFRESH: if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = LD_RFC;
                    if (ref_cnt == REF_LAST) st_n = S_MR_RUN;
                    else                     ref_inc = 1'b1;
                end
                S_MR_RUN:    if (t_zero) begin st_n = S_EMR_OCD;   t_load = 1'b1; t_val = LD_MRD; end
                S_EMR_OCD:   if (t_zero) begin st_n = S_EMR_EXIT;  t_load = 1'b1; t_val = LD_MRD; end
                S_EMR_EXIT:  if (t_zero) begin st_n = S_HOLD;      t_load = 1'b1; t_val = LD_MRD; end
                S_HOLD:      if (t_zero && dll_expired) st_n = S_DONE;
                S_DONE:      st_n = S_DONE;
                default:     st_n = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cke       = (st != S_IDLE);
        odt       = 1'b0;
        init_done = (st == S_DONE);
        fire      = t_zero && (st inside {S_PREA1, S_EMR2, S_EMR3, S_EMR_DLL, S_MR_DLLRST,
                                          S_PREA2, S_REFRESH, S_MR_RUN, S_EMR_OCD, S_EMR_EXIT});
        dll_start = fire && (st == S_MR_DLLRST);
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end

    ddr2_init_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    ddr2_init_dll_wait #(.LOCK_CYC(DLL_LOCK_CK)) u_dll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (st == S_IDLE),
        .start   (dll_start),
        .expired (dll_expired)
    );

    ddr2_init_cmd_enc #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_enc (
        .step     (st),
        .fire     (fire),
        .mr_cfg   (mr_cfg),
        .emr_cfg  (emr_cfg),
        .emr2_cfg (emr2_cfg),
        .emr3_cfg (emr3_cfg),
        .cmd      (cmd),
        .ba       (ba),
        .addr     (addr)
    );
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ROW_W-1:0]  addr,
    input logic              init_done
);
    logic [3:0] c;
    logic       is_nop, is_pre, is_ref, is_lmr;
    assign c      = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (c == 4'b0111);
    assign is_pre = (c == 4'b0010);
    assign is_ref = (c == 4'b0001);
    assign is_lmr = (c == 4'b0000);

    AST_CKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !cke);                                              // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (is_nop && ba == '0 && addr == '0 && !init_done));       // R1
    AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (is_nop && !init_done));                           // R2
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr[10] && ba == '0));                               // R3
    AST_REF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (addr == '0 && ba == '0));                             // R7
    AST_CMD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> (is_nop || is_pre || is_ref || is_lmr));                  // R13
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pwr_good) |=> init_done);                           // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (is_nop && cke));                                   // R10
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;
    localparam int PWR_TOT = 20000 + 40;   // 200 us + 400 ns at 10 ns
    localparam int TRP     = 2;            // 15 ns rounded up
    localparam int TRFC    = 13;           // 128 ns rounded up
    localparam int TMRD    = 2;
    localparam int NREF    = 2;
    localparam int LOCK    = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic [13:0] mr_cfg = 14'h0432, emr_cfg = 14'h0044, emr2_cfg = 14'h0080, emr3_cfg = 14'h0000;
    logic        cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [13:0] addr;

    always #5 clk = ~clk;

    ddr2_init_seq i_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .mr_cfg(mr_cfg), .emr_cfg(emr_cfg), .emr2_cfg(emr2_cfg), .emr3_cfg(emr3_cfg),
        .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    int n_chk = 0, n_fail = 0;
    int q_t[$];
    logic [3:0]  q_cmd[$];
    logic [1:0]  q_ba[$];
    logic [13:0] q_addr[$];
    string       q_tag[$];
    bit  active = 0, restarted = 0;
    int  t = 0, t_done = 0, runs = 0, done_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] emr_w(input logic [13:0] cfg, input logic [2:0] o);
        logic [13:0] w = cfg;
        w[0] = 1'b0;
        w[9:7] = o;
        return w;
    endfunction

    task automatic push(input int tt, input logic [3:0] c, input logic [1:0] b,
                        input logic [13:0] a, input string tg);
        q_t.push_back(tt); q_cmd.push_back(c); q_ba.push_back(b);
        q_addr.push_back(a); q_tag.push_back(tg);
    endtask

    task automatic build();
        int tt, dll;
        q_t.delete(); q_cmd.delete(); q_ba.delete(); q_addr.delete(); q_tag.delete();
        tt = PWR_TOT;  push(tt, 4'b0010, 2'd0, 14'h0400, "R2/R3");
        tt += TRP;     push(tt, 4'b0000, 2'd2, emr2_cfg, "R4");
        tt += TMRD;    push(tt, 4'b0000, 2'd3, emr3_cfg, "R4");
        tt += TMRD;    push(tt, 4'b0000, 2'd1, emr_w(emr_cfg, 3'b000), "R5");
        tt += TMRD;    dll = tt; push(tt, 4'b0000, 2'd0, mr_cfg | 14'h0100, "R6");
        tt += TMRD;    push(tt, 4'b0010, 2'd0, 14'h0400, "R3");
        tt += TRP;
        for (int i = 0; i < NREF; i++) begin
            push(tt, 4'b0001, 2'd0, 14'h0000, "R7");
            tt += TRFC;
        end
        push(tt, 4'b0000, 2'd0, mr_cfg & ~14'h0100, "R8");
        tt += TMRD;    push(tt, 4'b0000, 2'd1, emr_w(emr_cfg, 3'b111), "R9");
        tt += TMRD;    push(tt, 4'b0000, 2'd1, emr_w(emr_cfg, 3'b000), "R9");
        tt += TMRD;
        t_done = ((tt > dll + LOCK) ? tt : dll + LOCK) + 1;
    endtask

    // Reference model: advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            if (active) restarted = 1;
            active = 0;
        end else if (!active) begin
            active = 1; t = 0; runs++;
            build();
        end else begin
            t++;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        logic [3:0] ec; logic [1:0] eb; logic [13:0] ea; string tg; bit ed;
        ec = 4'b0111; eb = 2'd0; ea = 14'h0; tg = active ? "R13" : "R1"; ed = 0;
        if (active && t < PWR_TOT) tg = "R2";
        if (active && q_t.size() > 0 && q_t[0] == t) begin
            ec = q_cmd[0]; eb = q_ba[0]; ea = q_addr[0]; tg = q_tag[0];
            void'(q_t.pop_front()); void'(q_cmd.pop_front()); void'(q_ba.pop_front());
            void'(q_addr.pop_front()); void'(q_tag.pop_front());
        end
        if (restarted && active) tg = {tg, "/R12"};
        if (active && t >= t_done) ed = 1;
        check(cke == active, active ? "R2" : "R1", "cke", int'(cke), int'(active));
        check(odt == 1'b0, "R11", "odt", int'(odt), 0);
        check({cs_n, ras_n, cas_n, we_n} == ec, tg, "cmd", int'({cs_n, ras_n, cas_n, we_n}), int'(ec));
        check(ba == eb, tg, "ba", int'(ba), int'(eb));
        check(addr == ea, tg, "addr", int'(addr), int'(ea));
        check(init_done == ed, active ? "R10" : "R1", "init_done", int'(init_done), int'(ed));
        if (init_done) done_seen = runs;
    end

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (10) @(posedge clk);           // R1: power-good low keeps cke low
        #2 pwr_good = 1'b1;
        repeat (PWR_TOT + 300) @(posedge clk);
        check(done_seen == 1, "R10", "done reached run 1", done_seen, 1);
        #2 pwr_good = 1'b0;
        repeat (6) @(posedge clk);
        #2 begin
            mr_cfg = 14'h0952; emr_cfg = 14'h0387; emr2_cfg = 14'h0005; emr3_cfg = 14'h2001;
            pwr_good = 1'b1;
        end
        repeat (500) @(posedge clk);
        #2 pwr_good = 1'b0;                   // R12: drop mid power-up wait
        repeat (3) @(posedge clk);
        #2 pwr_good = 1'b1;
        repeat (PWR_TOT + 300) @(posedge clk);
        check(done_seen == 3, "R12", "done reached after restart", done_seen, 3);
        #3 finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        finish_up();
    end
endmodule